// File: doc/BRIEF.md
# Compare-to-Zero Branch and Next-Fetch-Address Unit

This unit sits at the decode stage of a small 32-bit pipeline. Each cycle it looks at the instruction just fetched, together with that instruction's address and the value read for its source register. If the word is a conditional immediate branch, the unit compares the register against zero and produces the next fetch address. That address is either the address plus the branch offset or the following sequential address. The unit also reports how many already-fetched instructions must be discarded as bubbles.

The offset is normally the sign-extended 16-bit field of the branch. When the valid instruction just before is an immediate-prefix word, the prefix's 16 bits supply the upper half of a full 32-bit offset. Each branch carries its own delay bit. When that bit is set, the next instruction always completes and fewer bubbles are charged. The unit also gates interrupt and break requests, so that none is taken between a prefix and the word it modifies, or between a delayed branch and its slot instruction. It flags any prefix, branch or break word that lands in a delay slot.

Top module: `brnpc_top`

## Requirements
- R1: A word is a conditional branch when bits [31:26] equal 6'b101111. Bit 25 is the delay bit, bits [24:21] hold the condition code, bits [20:16] hold the source register index (always driven on `ra_idx`), and bits [15:0] hold the immediate.
- R2: Condition codes compare the source value, as a signed number, against zero: 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal. Any other code is never taken.
- R3: For a valid word, `next_pc` is `pc` plus the offset when a branch is taken, and otherwise `pc` + 4. With no valid word, `next_pc` equals `pc`.
- R4: A valid word with bits [31:26] = 6'b101100 is an immediate prefix. The next valid word, and only that one, uses {prefix bits [15:0], own bits [15:0]} as its offset. Without a prefix the offset is bits [15:0] sign-extended. Idle cycles in between do not clear the prefix.
- R5: `bubble_cnt` is 0 for an invalid word, a non-branch or a branch that is not taken. It is 1 for a taken branch with the delay bit set and 2 for a taken branch with the delay bit clear.
- R6: A request is held off in any cycle whose valid word is a prefix or a branch with the delay bit set. It is also held off in an idle cycle while a prefix or a delay slot is still pending. Otherwise a break request is acknowledged on `brk_ack`, and an interrupt request is acknowledged on `irq_ack` only when no break is requested in the same cycle.
- R7: When the valid word that follows a branch with the delay bit set has opcode 6'b101100, 6'b101111 or 6'b101110 (break), `illegal_slot` is high for that cycle only. `next_pc` and `bubble_cnt` are still formed normally.
- R8: After reset no prefix and no delay slot is pending, so a request in an idle cycle is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | `instr` holds a real fetched word this cycle |
| instr | input | 32 | Fetched instruction word |
| pc | input | 32 | Address of `instr` |
| ra_val | input | 32 | Value of the register selected by `ra_idx` |
| irq_req | input | 1 | Interrupt request (level) |
| brk_req | input | 1 | External break request (level) |
| ra_idx | output | 5 | Source register index taken from the word |
| next_pc | output | 32 | Next fetch address |
| bubble_cnt | output | 2 | Number of fetched words to discard |
| irq_ack | output | 1 | Interrupt accepted after this cycle's word |
| brk_ack | output | 1 | Break accepted after this cycle's word |
| illegal_slot | output | 1 | Forbidden word found in a delay slot |

## Verification
All sixteen condition codes are swept against the source values zero, one, minus one, the largest positive value and the most negative value. This separates signed from unsigned comparison, shows where equality sits at each boundary, and confirms that the unused codes are never taken. Each case runs with both delay-bit values and with positive, negative and most-negative immediates, with and without a preceding prefix. This separates sign extension from the prefix merge and the two bubble counts. Request patterns are laid over prefix, delay-slot and idle cycles, and delay slots are filled with prefix, branch, break and ordinary words, so that the hold-off and illegal-slot paths are each exercised in isolation.

// File: rtl/brnpc_pkg.sv
package brnpc_pkg;
  localparam int XLEN  = 32;
  localparam int IMM_W = 16;
  localparam int OP_W  = 6;

  localparam logic [OP_W-1:0] OP_CBR = 6'b101111;
  localparam logic [OP_W-1:0] OP_PFX = 6'b101100;
  localparam logic [OP_W-1:0] OP_BRK = 6'b101110;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0, CC_NE = 4'd1, CC_LT = 4'd2,
    CC_LE = 4'd3, CC_GT = 4'd4, CC_GE = 4'd5
  } cc_e;

  typedef struct packed {
    logic             is_cbr;
    logic             is_pfx;
    logic             is_brk;
    logic             dly;
    logic [3:0]       cc;
    logic [4:0]       ra;
    logic [IMM_W-1:0] imm;
  } dec_t;

  // signed compare of a register value against zero
  function automatic logic cond_met(input logic [3:0] cc, input logic [XLEN-1:0] v);
    logic neg, zero;
    neg  = v[XLEN-1];
    zero = (v == '0);
    case (cc)
      CC_EQ:   cond_met = zero;
      CC_NE:   cond_met = !zero;
      CC_LT:   cond_met = neg;
      CC_LE:   cond_met = neg || zero;
      CC_GT:   cond_met = !neg && !zero;
      CC_GE:   cond_met = !neg;
      default: cond_met = 1'b0;
    endcase
  endfunction

  // branch offset: merged with a pending prefix or sign-extended
  function automatic logic [XLEN-1:0] form_offset(input logic use_hi,
                                                  input logic [IMM_W-1:0] hi,
                                                  input logic [IMM_W-1:0] lo);
    if (use_hi) form_offset = {hi, lo};
    else        form_offset = {{(XLEN-IMM_W){lo[IMM_W-1]}}, lo};
  endfunction
endpackage

// File: rtl/brnpc_decode.sv
module brnpc_decode
  import brnpc_pkg::*;
(
  input  logic [XLEN-1:0] word,
  output dec_t            dec
);
  localparam int OP_LSB = XLEN - OP_W;

  logic [OP_W-1:0] op;
  assign op = word[XLEN-1:OP_LSB];

  always_comb begin
    dec        = '0;
    dec.is_cbr = (op == OP_CBR);
    dec.is_pfx = (op == OP_PFX);
    dec.is_brk = (op == OP_BRK);
    dec.dly    = word[OP_LSB-1];
    dec.cc     = word[OP_LSB-2 -: 4];
    dec.ra     = word[OP_LSB-6 -: 5];
    dec.imm    = word[IMM_W-1:0];
  end
endmodule

// File: rtl/brnpc_cond.sv
module brnpc_cond
  import brnpc_pkg::*;
(
  input  logic            is_cbr,
  input  logic [3:0]      cc,
  input  logic [XLEN-1:0] ra_val,
  output logic            take
);
  assign take = is_cbr && cond_met(cc, ra_val);
endmodule

// File: rtl/brnpc_seq.sv
module brnpc_seq
  import brnpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  dec_t             dec,
  output logic             pfx_q,
  output logic [IMM_W-1:0] pfx_hi_q,
  output logic             slot_q,
  output logic             evt_hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q    <= 1'b0;
      pfx_hi_q <= '0;
      slot_q   <= 1'b0;
    end else if (vld) begin
      pfx_q  <= dec.is_pfx;
      slot_q <= dec.is_cbr && dec.dly;
      if (dec.is_pfx) pfx_hi_q <= dec.imm;
    end
  end

  always_comb begin
    if (vld) evt_hold = dec.is_pfx || (dec.is_cbr && dec.dly);
    else     evt_hold = pfx_q || slot_q;
  end
endmodule

// File: rtl/brnpc_top.sv
module brnpc_top
  import brnpc_pkg::*;
#(
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] ra_val,
  input  logic            irq_req,
  input  logic            brk_req,
  output logic [4:0]      ra_idx,
  output logic [XLEN-1:0] next_pc,
  output logic [1:0]      bubble_cnt,
  output logic            irq_ack,
  output logic            brk_ack,
  output logic            illegal_slot
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  dec_t             dec;
  logic             br_taken;
  logic             pfx_q;
  logic [IMM_W-1:0] pfx_hi_q;
  logic             slot_q;
  logic             evt_hold;
  logic [XLEN-1:0]  br_off;

  brnpc_decode u_dec (.word(instr), .dec(dec));

  brnpc_cond u_cond (
    .is_cbr(dec.is_cbr && instr_valid), .cc(dec.cc), .ra_val(ra_val), .take(br_taken)
  );

  brnpc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .vld(instr_valid), .dec(dec),
    .pfx_q(pfx_q), .pfx_hi_q(pfx_hi_q), .slot_q(slot_q), .evt_hold(evt_hold)
  );

  assign ra_idx = dec.ra;
  assign br_off = form_offset(pfx_q, pfx_hi_q, dec.imm);

  always_comb begin
    if (!instr_valid)  next_pc = pc;
    else if (br_taken) next_pc = pc + br_off;
    else               next_pc = pc + STEP;
  end

  always_comb begin
    if (br_taken) bubble_cnt = dec.dly ? 2'd1 : 2'd2;
    else          bubble_cnt = 2'd0;
  end

  assign brk_ack      = brk_req && !evt_hold;
  assign irq_ack      = irq_req && !brk_req && !evt_hold;
  assign illegal_slot = instr_valid && slot_q && (dec.is_pfx || dec.is_cbr || dec.is_brk);
endmodule

// File: rtl/brnpc_chk.sv
module brnpc_chk
  import brnpc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] next_pc,
  input logic [1:0]      bubble_cnt,
  input logic            irq_ack,
  input logic            brk_ack,
  input logic            illegal_slot,
  input logic            slot_q,
  input logic            pfx_q
);
  logic [OP_W-1:0] op;
  assign op = instr[XLEN-1 -: OP_W];

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (next_pc == pc) && (bubble_cnt == 2'd0));
  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && bubble_cnt == 2'd0) |-> next_pc == pc + 32'd4);
  assert_pfx_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && op == OP_PFX) |=> pfx_q);
  assert_pfx_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && op != OP_PFX) |=> !pfx_q);
  assert_two_bubbles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bubble_cnt == 2'd2) |-> instr_valid && op == OP_CBR && !instr[25]);
  assert_one_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bubble_cnt == 2'd1) |-> instr_valid && op == OP_CBR && instr[25]);
  assert_no_ack_on_pfx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && op == OP_PFX) |-> !(irq_ack || brk_ack));
  assert_single_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, brk_ack}));
  assert_slot_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_slot |-> instr_valid && slot_q);
endmodule

bind brnpc_top brnpc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .pc(pc),
  .next_pc(next_pc), .bubble_cnt(bubble_cnt), .irq_ack(irq_ack), .brk_ack(brk_ack),
  .illegal_slot(illegal_slot), .slot_q(slot_q), .pfx_q(pfx_q)
);

// File: tb/sim_brnpc_top.sv
module sim_brnpc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic [31:0] ra_val = '0;
  logic        irq_req = 1'b0;
  logic        brk_req = 1'b0;
  logic [4:0]  ra_idx;
  logic [31:0] next_pc;
  logic [1:0]  bubble_cnt;
  logic        irq_ack, brk_ack, illegal_slot;

  int n_cmp = 0;
  int n_bad = 0;

  // bench-side model state
  logic        m_pfx = 1'b0;
  logic [15:0] m_hi = '0;
  logic        m_slot = 1'b0;

  always #4 clk = ~clk;

  brnpc_top u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .pc(pc),
    .ra_val(ra_val), .irq_req(irq_req), .brk_req(brk_req), .ra_idx(ra_idx),
    .next_pc(next_pc), .bubble_cnt(bubble_cnt), .irq_ack(irq_ack), .brk_ack(brk_ack),
    .illegal_slot(illegal_slot)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected outcome from the requirement's arithmetic view: signed integer compare
  function automatic logic exp_take(input logic [3:0] cc, input logic [31:0] v);
    int signed s;
    s = $signed(v);
    case (cc)
      4'd0: return s == 0;
      4'd1: return s != 0;
      4'd2: return s < 0;
      4'd3: return s <= 0;
      4'd4: return s > 0;
      4'd5: return s >= 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] p,
                      input logic [31:0] r, input logic iq, input logic bk);
    logic is_br, is_pf, is_bk, d, tk, hold;
    logic [31:0] off, e_pc;
    logic [1:0] e_bub;
    @(negedge clk);
    instr_valid = v; instr = w; pc = p; ra_val = r; irq_req = iq; brk_req = bk;
    is_br = (w[31:26] == 6'b101111);
    is_pf = (w[31:26] == 6'b101100);
    is_bk = (w[31:26] == 6'b101110);
    d     = w[25];
    tk    = v && is_br && exp_take(w[24:21], r);
    off   = m_pfx ? {m_hi, w[15:0]} : 32'($signed(w[15:0]));
    e_pc  = !v ? p : (tk ? p + off : p + 32'd4);
    e_bub = !tk ? 2'd0 : (d ? 2'd1 : 2'd2);
    hold  = v ? (is_pf || (is_br && d)) : (m_pfx || m_slot);
    #3;
    chk("R1 ra_idx", {27'd0, ra_idx}, {27'd0, w[20:16]});
    chk(m_pfx ? "R2 R3 R4 next_pc" : "R2 R3 next_pc", next_pc, e_pc);
    chk("R5 bubble_cnt", {30'd0, bubble_cnt}, {30'd0, e_bub});
    chk("R6 brk_ack", {31'd0, brk_ack}, {31'd0, bk && !hold});
    chk("R6 irq_ack", {31'd0, irq_ack}, {31'd0, iq && !bk && !hold});
    chk("R7 illegal_slot", {31'd0, illegal_slot},
        {31'd0, v && m_slot && (is_pf || is_br || is_bk)});
    @(posedge clk);
    if (v) begin
      m_pfx  = is_pf;
      m_slot = is_br && d;
      if (is_pf) m_hi = w[15:0];
    end
  endtask

  function automatic logic [31:0] mk_br(input logic d, input logic [3:0] cc,
                                        input logic [4:0] ra, input logic [15:0] imm);
    return {6'b101111, d, cc, ra, imm};
  endfunction

  localparam logic [31:0] NOP = 32'h0000_0000;

  initial begin
    logic [31:0] ra_set [5];
    logic [15:0] imm_set [3];
    int it;
    ra_set[0] = 32'h0; ra_set[1] = 32'h1; ra_set[2] = 32'hFFFF_FFFF;
    ra_set[3] = 32'h7FFF_FFFF; ra_set[4] = 32'h8000_0000;
    imm_set[0] = 16'h0010; imm_set[1] = 16'hFFF0; imm_set[2] = 16'h8000;
    it = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R8: straight out of reset, idle cycles acknowledge at once
    step(1'b0, NOP, 32'h100, 0, 1'b1, 1'b0);
    step(1'b0, NOP, 32'h100, 0, 1'b1, 1'b1);

    // sweep: condition x source x delay x immediate x prefix
    for (int cc = 0; cc < 16; cc++)
      for (int ri = 0; ri < 5; ri++)
        for (int d = 0; d < 2; d++)
          for (int ii = 0; ii < 3; ii++)
            for (int pf = 0; pf < 2; pf++) begin
              logic [31:0] p;
              p = 32'h4000_0000 + 32'(it) * 32'h40;
              if (pf == 1) begin
                step(1'b1, {6'b101100, 10'd0, 16'h00A5 ^ 16'(cc)}, p - 4, 0, it[0], 1'b0);
                if (it[2]) step(1'b0, NOP, p, 0, 1'b1, 1'b0);
              end
              step(1'b1, mk_br(d[0], 4'(cc), 5'(ri + cc), imm_set[ii]), p,
                   ra_set[ri], it[0], it[1]);
              if (d == 1) begin
                if (it[3]) step(1'b0, NOP, p + 4, 0, 1'b1, 1'b0);
                step(1'b1, NOP, p + 4, 0, it[1], it[0]);
              end
              it++;
            end

    // R4: prefix cleared by one following word that does not use it
    step(1'b1, {6'b101100, 10'd0, 16'h7777}, 32'h200, 0, 1'b0, 1'b0);
    step(1'b1, NOP, 32'h204, 0, 1'b1, 1'b0);
    step(1'b1, mk_br(1'b0, 4'd0, 5'd1, 16'hFFF8), 32'h208, 0, 1'b0, 1'b0);

    // R7: delay slot filled with prefix, break, branch, ordinary word
    step(1'b1, mk_br(1'b1, 4'd0, 5'd2, 16'h0020), 32'h300, 0, 1'b1, 1'b0);
    step(1'b1, {6'b101100, 10'd0, 16'h0001}, 32'h304, 0, 1'b1, 1'b0);
    step(1'b1, NOP, 32'h308, 0, 1'b0, 1'b0);
    step(1'b1, mk_br(1'b1, 4'd1, 5'd2, 16'h0020), 32'h30C, 0, 1'b0, 1'b1);
    step(1'b1, {6'b101110, 26'd0}, 32'h310, 0, 1'b1, 1'b1);
    step(1'b1, mk_br(1'b1, 4'd5, 5'd3, 16'h0040), 32'h314, 5, 1'b1, 1'b0);
    step(1'b1, mk_br(1'b0, 4'd5, 5'd3, 16'h0040), 32'h318, 5, 1'b1, 1'b0);
    step(1'b1, mk_br(1'b1, 4'd3, 5'd4, 16'h0008), 32'h320, 1, 1'b0, 1'b0);
    step(1'b0, NOP, 32'h324, 0, 1'b1, 1'b1);
    step(1'b1, NOP, 32'h324, 0, 1'b1, 1'b0);
    step(1'b0, NOP, 32'h328, 0, 1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule